// File: doc/BRIEF.md
# Pixel Packing Double-Buffered Frame Capture

This block takes one monochrome frame from an 8-bit pixel stream and passes it to a processor in fixed-size groups. A start command arms the sensor stream. The frame-sync input is filtered so that short glitches are ignored. The first clean rising edge of that filtered sync opens a capture window. While the window is open, accepted pixels are packed four to a 32-bit word. Eight packed words form a group in a first-level buffer.

When a group is complete, a coordinator copies it into a second-level buffer and raises a ready flag. The processor reads the eight words through a word selector and acknowledges. If the first level completes another group while the second level is still waiting, that group is dropped and a sticky overflow flag is raised. After the final group of the frame is acknowledged, a one-cycle done pulse is issued and the block returns to idle.

Top module: `fg_capture_top`

## Requirements
- R1: After synchronous reset, `sensor_run`, `in_win`, `rd_valid`, `frame_done` and `overflow` are all 0.
- R2: A `start` pulse while idle raises `sensor_run` on the next edge. `in_win` stays 0 until a filtered sync rising edge is seen.
- R3: `sync_in` only counts as changed after it holds the new level for 4 consecutive clock samples; a high pulse of 3 samples is ignored. `in_win` rises on the 5th edge after the first of 4 consecutive high samples.
- R4: A pixel is accepted only on an edge where both `in_win` and `pix_valid` are 1. Bytes offered at any other time never appear in the output words.
- R5: Packing is little-endian. The first accepted pixel of a word goes to bits [7:0], the second to [15:8], the third to [23:16] and the fourth to [31:24].
- R6: `rd_valid` rises two edges after the edge that accepts the 32nd pixel of a group. `rd_word` then returns word `rd_sel` (0 = oldest) of that group.
- R7: The second-level contents stay unchanged while `rd_valid` is 1 and `ack` is 0. `rd_valid` falls on the edge where `ack` is sampled 1.
- R8: A group that completes while `rd_valid` is 1 and `ack` is 0 is discarded. In that case `overflow` goes to 1 two edges after its last pixel and stays 1 until the next accepted `start`.
- R9: After `FRAME_W*FRAME_H` accepted pixels, `in_win` falls on the next edge. Acknowledging the final group gives a one-cycle `frame_done` pulse after that edge, and `sensor_run` returns to 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame capture (acted on only when idle) |
| sync_in | input | 1 | Raw frame-sync level from the sensor |
| pix_valid | input | 1 | Pixel byte present on `pix_data` |
| pix_data | input | 8 | Pixel byte |
| ack | input | 1 | Processor has consumed the ready group |
| rd_sel | input | 3 | Word index within the ready group |
| sensor_run | output | 1 | Sensor stream enable, high from start to frame end |
| in_win | output | 1 | Capture window open |
| rd_valid | output | 1 | Second-level group ready for reading |
| rd_word | output | 32 | Selected word of the ready group |
| frame_done | output | 1 | One-cycle pulse after the final group is acknowledged |
| overflow | output | 1 | Sticky flag: a group was dropped |

## Verification
Each result is due a fixed number of edges after its stimulus:
- one edge from `start` to `sensor_run`;
- five edges from the first high sync sample to `in_win`;
- one edge from the last frame pixel to `in_win` falling;
- two edges from a group's last pixel to `rd_valid` or `overflow`;
- one edge from `ack` to `rd_valid` falling and to `frame_done`.

The bench drives all inputs on the falling clock edge. It counts those edges after each stimulus and samples the outputs there. This checks both the cycle before a result is due, where the output must still be low, and the cycle where it must have changed. Expected words are formed from the driven bytes and queued. They are compared word by word through `rd_sel` while `rd_valid` is held.

// File: rtl/fg_pkg.sv
// Shared types for the frame capture block.
package fg_pkg;

    // Capture controller states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DRAIN = 2'd3
    } cap_state_t;

endpackage

// File: rtl/fg_debounce.sv
// Level filter for the sensor frame-sync.
// The output takes a new level only after the input has held that level
// for STABLE consecutive samples.
// Assumes: the input is already synchronous to clk.
module fg_debounce #(
    parameter int STABLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = (STABLE > 1) ? $clog2(STABLE) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STABLE - 1);

    logic [CW-1:0] cnt;

    // Count samples that differ from the output; commit after STABLE of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b0;
            cnt   <= '0;
        end else if (raw == clean) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            clean <= raw;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DEB_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clean) |-> $past(raw)); // R3

endmodule

// File: rtl/fg_packer.sv
// Packs LANES consecutive accepted pixels into one word, first pixel in the
// lowest lane. Pulses word_vld for one cycle after the last lane is filled.
// Assumes: clr is asserted between frames to realign the lane counter.
module fg_packer #(
    parameter int PIX_W = 8,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   pix_en,
    input  logic [PIX_W-1:0]       pix,
    output logic                   word_vld,
    output logic [PIX_W*LANES-1:0] word
);
    localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LW-1:0] LANE_LAST = LW'(LANES - 1);

    logic [LW-1:0] lane;

    // Place each accepted pixel in its lane and flag a finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane     <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else if (clr) begin
            lane     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (pix_en) begin
                word[lane*PIX_W +: PIX_W] <= pix;
                if (lane == LANE_LAST) begin
                    lane     <= '0;
                    word_vld <= 1'b1;
                end else begin
                    lane <= lane + 1'b1;
                end
            end
        end
    end

    AST_WORD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R5

endmodule

// File: rtl/fg_group_buf.sv
// Two-level group buffer.
// The first level gathers DEPTH words in arrival order and pulses full when
// the last slot is written. A trig pulse copies all slots into the second
// level, which is read through rd_sel.
// Assumes: trig only arrives while full is high, and at least two cycles
// separate words.
module fg_group_buf #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [WORD_W-1:0]        wr_word,
    input  logic                     trig,
    input  logic [$clog2(DEPTH)-1:0] rd_sel,
    output logic                     full,
    output logic [WORD_W-1:0]        rd_word
);
    localparam int SW = $clog2(DEPTH);
    localparam logic [SW-1:0] IDX_LAST = SW'(DEPTH - 1);

    logic [WORD_W-1:0] lvl1 [DEPTH];
    logic [WORD_W-1:0] lvl2 [DEPTH];
    logic [SW-1:0]     idx;

    // Advance the write slot and flag the group's last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            full <= 1'b0;
        end else if (clr) begin
            idx  <= '0;
            full <= 1'b0;
        end else begin
            full <= wr_en && (idx == IDX_LAST);
            if (wr_en) begin
                idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // First level: capture the word addressed by the write slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl1[g] <= '0;
            end else if (wr_en && (idx == SW'(g))) begin
                lvl1[g] <= wr_word;
            end
        end

        // Second level: take a snapshot of the first level on trig.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl2[g] <= '0;
            end else if (trig) begin
                lvl2[g] <= lvl1[g];
            end
        end
    end

    assign rd_word = lvl2[rd_sel];

    AST_TRIG_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> full); // R6

endmodule

// File: rtl/fg_coord.sv
// Handshake coordinator between the group buffer and the processor.
// It issues the copy pulse when a group is full and the second level is
// free (or being released this cycle), and holds ready until ack.
// It counts completed groups, flags a dropped group as overflow, and
// reports the acknowledge of the frame's last group.
// Assumes: clr is pulsed at frame start.
module fg_coord #(
    parameter int GROUPS = 3456
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic all_ready,
    input  logic ack,
    output logic trig,
    output logic rd_valid,
    output logic overflow,
    output logic last_ack
);
    localparam int GW = $clog2(GROUPS + 1);
    localparam logic [GW-1:0] G_ALL = GW'(GROUPS);

    logic [GW-1:0] g_seen;

    assign trig     = all_ready && (!rd_valid || ack);
    assign last_ack = ack && rd_valid && !all_ready && (g_seen == G_ALL);

    // Ready flag: set by a copy, cleared by the processor acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_valid <= 1'b0;
        end else if (trig) begin
            rd_valid <= 1'b1;
        end else if (ack) begin
            rd_valid <= 1'b0;
        end
    end

    // Sticky overflow and the count of completed groups.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            overflow <= 1'b0;
            g_seen   <= '0;
        end else if (all_ready) begin
            g_seen <= g_seen + 1'b1;
            if (rd_valid && !ack) begin
                overflow <= 1'b1;
            end
        end
    end

    AST_NO_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !clr |=> overflow); // R8
    AST_VALID_FROM_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(trig)); // R6
    AST_SEEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        g_seen <= G_ALL); // R9

endmodule

// File: rtl/fg_capture_top.sv
// Single-frame capture: arms the sensor on start and opens the capture
// window on the filtered sync rise. It packs pixels into words, buffers
// them in groups and hands each group to the processor with a
// ready/acknowledge handshake.
// Assumes: all inputs are synchronous to clk, and FRAME_W*FRAME_H is a
// multiple of LANES*GROUP_WORDS.
module fg_capture_top #(
    parameter int FRAME_W     = 384,
    parameter int FRAME_H     = 288,
    parameter int PIX_W       = 8,
    parameter int LANES       = 4,
    parameter int GROUP_WORDS = 8,
    parameter int SYNC_STABLE = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           sync_in,
    input  logic                           pix_valid,
    input  logic [PIX_W-1:0]               pix_data,
    input  logic                           ack,
    input  logic [$clog2(GROUP_WORDS)-1:0] rd_sel,
    output logic                           sensor_run,
    output logic                           in_win,
    output logic                           rd_valid,
    output logic [PIX_W*LANES-1:0]         rd_word,
    output logic                           frame_done,
    output logic                           overflow
);
    import fg_pkg::*;

    localparam int WORD_W    = PIX_W * LANES;
    localparam int FRAME_PIX = FRAME_W * FRAME_H;
    localparam int GROUPS    = FRAME_PIX / (LANES * GROUP_WORDS);
    localparam int PCNT_W    = $clog2(FRAME_PIX);
    localparam logic [PCNT_W-1:0] PIX_LAST = PCNT_W'(FRAME_PIX - 1);

    cap_state_t        state;
    logic [PCNT_W-1:0] pcnt;
    logic              deb_sync, deb_q;
    logic              clr, pix_en, sync_rise;
    logic              word_vld, all_ready, trig, last_ack;
    logic [WORD_W-1:0] word;

    assign clr        = start && (state == ST_IDLE);
    assign in_win     = (state == ST_CAPT);
    assign sensor_run = (state != ST_IDLE);
    assign pix_en     = in_win && pix_valid;
    assign sync_rise  = deb_sync && !deb_q;

    fg_debounce #(.STABLE(SYNC_STABLE)) u_deb (
        .clk(clk), .rst_n(rst_n), .raw(sync_in), .clean(deb_sync)
    );

    fg_packer #(.PIX_W(PIX_W), .LANES(LANES)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(clr), .pix_en(pix_en), .pix(pix_data),
        .word_vld(word_vld), .word(word)
    );

    fg_group_buf #(.WORD_W(WORD_W), .DEPTH(GROUP_WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(word_vld), .wr_word(word),
        .trig(trig), .rd_sel(rd_sel), .full(all_ready), .rd_word(rd_word)
    );

    fg_coord #(.GROUPS(GROUPS)) u_coord (
        .clk(clk), .rst_n(rst_n), .clr(clr), .all_ready(all_ready), .ack(ack),
        .trig(trig), .rd_valid(rd_valid), .overflow(overflow), .last_ack(last_ack)
    );

    // Remember the previous filtered sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) deb_q <= 1'b0;
        else        deb_q <= deb_sync;
    end

    // Frame controller: idle -> armed -> capturing -> draining -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pcnt       <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (state)
                ST_IDLE:  if (start) state <= ST_ARM;
                ST_ARM: begin
                    if (sync_rise) begin
                        state <= ST_CAPT;
                        pcnt  <= '0;
                    end
                end
                ST_CAPT: begin
                    if (pix_en) begin
                        if (pcnt == PIX_LAST) state <= ST_DRAIN;
                        else                  pcnt  <= pcnt + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (last_ack) begin
                        state      <= ST_IDLE;
                        frame_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_WIN_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_win) |-> deb_sync); // R3
    AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_win) |-> $past(pix_en)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R9
    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !ack |=> (!$stable(rd_sel) || $stable(rd_word))); // R7

endmodule

// File: tb/sim_fg_capture_top.sv
module sim_fg_capture_top;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 16;
    localparam int FH = 4;

    logic        clk, rst_n, start, sync_in, pix_valid, ack;
    logic [7:0]  pix_data;
    logic [2:0]  rd_sel;
    logic        sensor_run, in_win, rd_valid, frame_done, overflow;
    logic [31:0] rd_word;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q [$];
    logic [31:0] acc;
    int          nb = 0;
    logic [31:0] first_word;

    fg_capture_top #(.FRAME_W(FW), .FRAME_H(FH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sync_in(sync_in),
        .pix_valid(pix_valid), .pix_data(pix_data), .ack(ack), .rd_sel(rd_sel),
        .sensor_run(sensor_run), .in_win(in_win), .rd_valid(rd_valid),
        .rd_word(rd_word), .frame_done(frame_done), .overflow(overflow)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: offer one accepted pixel and queue the expected word once complete.
    task automatic send_pix(input logic [7:0] v);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = v;
        acc[nb*8 +: 8] = v;
        nb++;
        if (nb == 4) begin
            exp_q.push_back(acc);
            nb = 0;
        end
    endtask

    // Monitor: pop the expected group and compare it word by word.
    task automatic read_group(input string req);
        for (int s = 0; s < 8; s++) begin
            rd_sel = 3'(s);
            #1;
            chk(req, rd_word, exp_q.pop_front());
        end
        rd_sel = 3'd0;
    endtask

    // Send a 32-pixel group, optionally with junk gaps; leave pix_valid low after.
    task automatic send_group(input int seed, input bit gaps);
        for (int i = 0; i < 32; i++) begin
            send_pix(8'(seed + i * 7));
            if (gaps && (i % 5 == 4) && i != 31) begin
                @(negedge clk);
                pix_valid = 1'b0;
                pix_data  = 8'hFF;
            end
        end
    endtask

    task automatic pulse_ack;
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; start = 0; sync_in = 0; pix_valid = 0; pix_data = 0;
        ack = 0; rd_sel = 0; acc = 0;
        repeat (3) @(negedge clk);
        chk("R1 sensor_run", 32'(sensor_run), 0);
        chk("R1 in_win", 32'(in_win), 0);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 frame_done", 32'(frame_done), 0);
        chk("R1 overflow", 32'(overflow), 0);
        rst_n = 1;

        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R2 sensor_run", 32'(sensor_run), 1);
        chk("R2 in_win", 32'(in_win), 0);

        // Glitch of 3 samples with junk pixels offered outside the window (R4).
        sync_in = 1; pix_valid = 1; pix_data = 8'hEE;
        repeat (3) @(negedge clk);
        sync_in = 0;
        repeat (6) @(negedge clk);
        chk("R3 glitch", 32'(in_win), 0);
        pix_valid = 0;

        // Stable high: window opens on the 5th edge.
        sync_in = 1;
        repeat (4) @(negedge clk);
        chk("R3 early", 32'(in_win), 0);
        @(negedge clk);
        chk("R3 open", 32'(in_win), 1);

        // Frame 1, group 1 with gaps.
        send_group(1, 1'b1);
        @(negedge clk); pix_valid = 0; pix_data = 8'hAA;
        chk("R6 t+1", 32'(rd_valid), 0);
        @(negedge clk);
        chk("R6 t+2", 32'(rd_valid), 0);
        @(negedge clk);
        chk("R6 ready", 32'(rd_valid), 1);
        rd_sel = 0; #1;
        first_word = rd_word;
        chk("R4 first byte", 32'(rd_word[7:0]), 32'h01);
        chk("R5 lane order", rd_word, {8'd22, 8'd15, 8'd8, 8'd1});
        read_group("R5 group");

        // Group 2 while the first is pending: dropped, overflow set.
        send_group(9, 1'b0);
        @(negedge clk); pix_valid = 0;
        chk("R9 window closed", 32'(in_win), 0);
        @(negedge clk);
        chk("R8 not yet", 32'(overflow), 0);
        @(negedge clk);
        chk("R8 overflow", 32'(overflow), 1);
        chk("R7 still ready", 32'(rd_valid), 1);
        rd_sel = 0; #1;
        chk("R8 old group kept", rd_word, first_word);
        repeat (8) void'(exp_q.pop_front());
        chk("R9 no early done", 32'(frame_done), 0);

        pulse_ack;
        chk("R7 released", 32'(rd_valid), 0);
        chk("R9 done", 32'(frame_done), 1);
        chk("R9 run off", 32'(sensor_run), 0);
        @(negedge clk);
        chk("R9 pulse", 32'(frame_done), 0);
        chk("R8 sticky", 32'(overflow), 1);

        // Frame 2: overflow cleared by start, prompt acks.
        sync_in = 0;
        repeat (6) @(negedge clk);
        start = 1;
        @(negedge clk); start = 0;
        chk("R8 cleared", 32'(overflow), 0);
        sync_in = 1;
        repeat (5) @(negedge clk);
        chk("R3 reopen", 32'(in_win), 1);

        send_group(40, 1'b0);
        @(negedge clk); pix_valid = 0;
        @(negedge clk);
        chk("R6 t+2 again", 32'(rd_valid), 0);
        @(negedge clk);
        chk("R6 ready again", 32'(rd_valid), 1);
        read_group("R6 group A");
        pulse_ack;
        chk("R7 released A", 32'(rd_valid), 0);
        chk("R9 not last", 32'(frame_done), 0);

        send_group(77, 1'b1);
        @(negedge clk); pix_valid = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 ready B", 32'(rd_valid), 1);
        read_group("R6 group B");
        chk("R8 no overflow", 32'(overflow), 0);
        pulse_ack;
        chk("R9 done 2", 32'(frame_done), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule